// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits behind the command decoder of a serial memory and turns a stream of incoming write bytes into a timed program operation. A start strobe carries a 16-bit byte address. Each later data strobe stores one byte in a page-sized staging buffer. The offset inside the page then advances and wraps at the page end, so the page bits never change. Each byte arrives with an allow flag from the protection logic. Only bytes that were both received and allowed are marked for commit.

Nothing is programmed while bytes are still arriving. When the chip-select release event arrives after at least one writable byte, the block raises a busy flag for a fixed number of clock cycles. This stands in for the self-timed program time. During that window it walks the page once, in ascending offset order, and presents every marked byte on a memory write port. When the window closes, the block sends a one-cycle pulse to clear the write enable latch. While busy, the block ignores every new start, byte or release event.

Top module: `pwb_sequencer`

## Requirements
- R1: After reset, busy, wel_clr and mem_we are all 0.
- R2: Only bits 12..0 of the start address are used. Bits 15..13 have no effect on the committed address, which is {page, offset} with page = bits 12..6 and offset = bits 5..0.
- R3: Each accepted byte goes to the current offset, and then only the offset increments. Past offset 63 it wraps to offset 0 of the same page, and a later byte at an offset overwrites the earlier one.
- R4: mem_we is never asserted while bytes are being loaded. It is asserted only while busy is 1.
- R5: A release event sampled on edge E, after a start and at least one writable byte, sets busy from E to E+PROG_CYCLES. That is exactly PROG_CYCLES cycles.
- R6: wel_clr is a single-cycle pulse in the cycle right after busy falls.
- R7: While busy is 1, wr_start, byte_vld and cs_rise are ignored. The committed page and data do not change, and busy is neither extended nor restarted.
- R8: Only offsets that received a byte are written. Every other byte of the page is left untouched, and each written offset carries the last byte loaded there.
- R9: A release event with no data byte received since the start causes no busy window, no write and no wel_clr.
- R10: A byte whose byte_ok is 0 is not written. If no received byte was writable, the release event causes no busy window, no write and no wel_clr.
- R11: Commit writes go out one per cycle, in strictly ascending offset order, all within the busy window.
- R12: Bytes and a release event that arrive with no start since the last release are ignored and cause no program cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Start of a write sequence, one-cycle strobe |
| wr_addr | input | 16 | Byte address taken with wr_start |
| byte_vld | input | 1 | One data byte received, one-cycle strobe |
| byte_data | input | 8 | Data byte taken with byte_vld |
| byte_ok | input | 1 | Protection verdict for the address of the current byte (1 = writable) |
| cs_rise | input | 1 | Chip-select release event, one-cycle strobe |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | One-cycle pulse that clears the write enable latch |
| mem_we | output | 1 | Memory array write enable |
| mem_addr | output | 13 | Memory array byte address |
| mem_wdata | output | 8 | Memory array write data |

## Verification
Take E as the edge that samples the release event. Busy is due in the cycle after E and stays high for PROG_CYCLES cycles. wel_clr is due in the one cycle after that, and the commit write for offset k is sampled on edge E+k+1. The bench drives every strobe on the falling edge. It then counts busy cycles and checks wel_clr on the falling edges that follow, so each check samples a stable value in its due cycle. Commit writes are recorded at the rising edges and compared against the bench's page model once the window has closed.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_RUN  = 1'b1
    } timer_st_e;

endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int PAGE_BYTES = 64,
    parameter int SIG_BITS   = 13,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = SIG_BITS - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_start,
    input  logic [SIG_BITS-1:0]   ld_addr,
    input  logic                  ld_byte,
    input  logic                  ld_ok,
    input  logic [DATA_W-1:0]     ld_data,
    input  logic [OFF_W-1:0]      rd_slot,
    output logic [PG_W-1:0]       page_o,
    output logic [PAGE_BYTES-1:0] mask_o,
    output logic [DATA_W-1:0]     rd_data_o
);

    typedef struct packed {
        logic [OFF_W-1:0]                    ptr;
        logic [PG_W-1:0]                     page;
        logic [PAGE_BYTES-1:0]               mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]   data;
    } buf_t;

    buf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_start) begin
            s_d.ptr  = ld_addr[OFF_W-1:0];
            s_d.page = ld_addr[SIG_BITS-1:OFF_W];
            s_d.mask = '0;
        end else if (ld_byte) begin
            s_d.data[s_q.ptr] = ld_data;
            s_d.mask[s_q.ptr] = ld_ok;
            s_d.ptr           = s_q.ptr + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign page_o    = s_q.page;
    assign mask_o    = s_q.mask;
    assign rd_data_o = s_q.data[rd_slot];

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_byte && !ld_start) |=> $stable(page_o));

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int LEN    = 1000,
    localparam int CNT_W = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy_o,
    output logic done_o
);
    import pwb_pkg::*;

    typedef struct packed {
        timer_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            T_IDLE: begin
                if (go) begin
                    s_d.st  = T_RUN;
                    s_d.cnt = CNT_W'(LEN - 1);
                end
            end
            default: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = T_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: T_IDLE, cnt: '0, done: 1'b0};
        else        s_q <= s_d;
    end

    assign busy_o = (s_q.st == T_RUN);
    assign done_o = s_q.done;

    // R6
    done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/pwb_commit_scan.sv
module pwb_commit_scan #(
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             active_o,
    output logic [OFF_W-1:0] slot_o
);

    typedef struct packed {
        logic             active;
        logic [OFF_W-1:0] slot;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.slot   = '0;
            end
        end else if (s_q.slot == OFF_W'(PAGE_BYTES - 1)) begin
            s_d.active = 1'b0;
        end else begin
            s_d.slot = s_q.slot + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;
    assign slot_o   = s_q.slot;

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer #(
    parameter int PAGE_BYTES  = 64,
    parameter int ADDR_W      = 16,
    parameter int SIG_BITS    = 13,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = SIG_BITS - OFF_W,
    localparam int PROG_LEN   = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_start,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                byte_vld,
    input  logic [DATA_W-1:0]   byte_data,
    input  logic                byte_ok,
    input  logic                cs_rise,
    output logic                busy,
    output logic                wel_clr,
    output logic                mem_we,
    output logic [SIG_BITS-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata
);

    typedef struct packed {
        logic armed;
    } seq_t;

    seq_t s_d, s_q;

    logic                  start_acc, byte_acc, go;
    logic [PG_W-1:0]       page;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     rd_data;
    logic                  scan_act;
    logic [OFF_W-1:0]      slot;
    logic                  addr_hi_unused;

    assign addr_hi_unused = ^wr_addr[ADDR_W-1:SIG_BITS];

    assign start_acc = wr_start && !busy;
    assign byte_acc  = byte_vld && s_q.armed && !busy && !wr_start;
    assign go        = cs_rise && s_q.armed && !busy && !wr_start && (|mask);

    always_comb begin
        s_d = s_q;
        if (!busy) begin
            if (start_acc)    s_d.armed = 1'b1;
            else if (cs_rise) s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    pwb_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .SIG_BITS   (SIG_BITS),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_start  (start_acc),
        .ld_addr   (wr_addr[SIG_BITS-1:0]),
        .ld_byte   (byte_acc),
        .ld_ok     (byte_ok),
        .ld_data   (byte_data),
        .rd_slot   (slot),
        .page_o    (page),
        .mask_o    (mask),
        .rd_data_o (rd_data)
    );

    pwb_cycle_timer #(
        .LEN (PROG_LEN)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .busy_o (busy),
        .done_o (wel_clr)
    );

    pwb_commit_scan #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .active_o (scan_act),
        .slot_o   (slot)
    );

    assign mem_we    = scan_act && mask[slot];
    assign mem_addr  = {page, slot};
    assign mem_wdata = rd_data;

    // R4
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R5
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    // R7
    busy_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[SIG_BITS-1:OFF_W]));

endmodule

// File: tb/sim_pwb_sequencer.sv
`timescale 1ns/1ps
module sim_pwb_sequencer;

    localparam int P = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0;
    logic [15:0] wr_addr = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_ok = 1'b0;
    logic        cs_rise = 1'b0;
    logic        busy, wel_clr, mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #2 clk = ~clk;

    pwb_sequencer #(.PROG_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_ok(byte_ok),
        .cs_rise(cs_rise), .busy(busy), .wel_clr(wel_clr), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int fails  = 0;
    int n_wr   = 0;
    logic [12:0] log_a [128];
    logic [7:0]  log_d [128];

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            log_a[n_wr % 128] <= mem_addr;
            log_d[n_wr % 128] <= mem_wdata;
            n_wr <= n_wr + 1;
        end
    end

    logic [7:0]  exp_d [64];
    logic [63:0] exp_m;
    logic [6:0]  exp_pg;
    bit          prot_on = 1'b0;
    logic [12:0] prot_lo = '0;

    function automatic bit ok_of(logic [12:0] a);
        return !(prot_on && (a >= prot_lo));
    endfunction

    task automatic chk(bit c, string req, int act, int exp);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic idle_inputs();
        wr_start = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0; byte_ok = 1'b0;
    endtask

    // Release chip select and check the whole program window
    task automatic commit(bit junk, int base);
        bit expect_prog;
        int cnt;
        int nw;
        int prev;
        expect_prog = (exp_m != '0);
        // R4: no write during loading
        chk(n_wr == base, "R4 writes during load", n_wr - base, 0);
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        if (expect_prog) begin
            chk(busy == 1'b1, "R5 busy after release", busy, 1);
            cnt = 0;
            while (busy && cnt < 3 * P) begin
                cnt++;
                if (junk && cnt >= 3 && cnt <= 8) begin
                    wr_start  = ($urandom % 2) == 0;
                    wr_addr   = 16'($urandom);
                    byte_vld  = 1'b1;
                    byte_data = 8'($urandom);
                    byte_ok   = 1'b1;
                    cs_rise   = (cnt == 5);
                end else begin
                    idle_inputs();
                end
                @(negedge clk);
            end
            idle_inputs();
            chk(cnt == P, "R5/R7 busy length", cnt, P);
            chk(wel_clr == 1'b1, "R6 wel_clr after busy", wel_clr, 1);
            @(negedge clk);
            chk(wel_clr == 1'b0, "R6 wel_clr single cycle", wel_clr, 0);
            chk(busy == 1'b0, "R7 no restart", busy, 0);
            nw = n_wr - base;
            chk(nw == $countones(exp_m), "R8/R10 write count", nw, $countones(exp_m));
            prev = -1;
            for (int k = 0; k < nw && k < 64; k++) begin
                int idx;
                int off;
                idx = (base + k) % 128;
                off = int'(log_a[idx][5:0]);
                chk(log_a[idx][12:6] == exp_pg, "R2/R3 page of write", int'(log_a[idx][12:6]), int'(exp_pg));
                chk(exp_m[off] == 1'b1, "R8/R10 write to unmarked offset", off, 1);
                chk(log_d[idx] == exp_d[off], "R3/R7 write data", int'(log_d[idx]), int'(exp_d[off]));
                chk(off > prev, "R11 ascending order", off, prev + 1);
                prev = off;
            end
        end else begin
            repeat (6) begin
                chk(busy == 1'b0, "R9/R10 no busy", busy, 0);
                chk(wel_clr == 1'b0, "R9/R10 no wel_clr", wel_clr, 0);
                @(negedge clk);
            end
            chk(n_wr == base, "R9/R10 no write", n_wr - base, 0);
        end
    endtask

    task automatic txn(logic [15:0] addr, int n, bit junk);
        logic [5:0] off;
        int base;
        base = n_wr;
        wr_start = 1'b1;
        wr_addr  = addr;
        @(negedge clk);
        wr_start = 1'b0;
        exp_pg = addr[12:6];
        off    = addr[5:0];
        exp_m  = '0;
        for (int i = 0; i < n; i++) begin
            byte_vld  = 1'b1;
            byte_data = 8'($urandom);
            byte_ok   = ok_of({exp_pg, off});
            exp_d[off] = byte_data;
            exp_m[off] = byte_ok;
            off = off + 6'd1;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        byte_ok  = 1'b0;
        chk(mem_we == 1'b0, "R4 mem_we idle before release", mem_we, 0);
        commit(junk, base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
    end

    initial begin
        int base;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(wel_clr == 1'b0, "R1 wel_clr reset", wel_clr, 0);
        chk(mem_we == 1'b0, "R1 mem_we reset", mem_we, 0);

        // R2: high address bits set, no protection
        txn(16'hE123, 5, 1'b0);
        // R3 wrap inside page with overwrite, R7 junk during busy
        txn(16'h0A7C, 70, 1'b1);
        // R9: start then release with no bytes
        txn(16'h0400, 0, 1'b0);
        // R10: everything protected
        prot_on = 1'b1; prot_lo = 13'h0000;
        txn(16'h1F00, 4, 1'b0);
        // R10: partial protection inside one page
        prot_lo = 13'h0A50;
        txn(16'h0A48, 20, 1'b1);
        prot_on = 1'b0;

        // R12: bytes and release with no start
        base = n_wr;
        repeat (3) begin
            byte_vld = 1'b1; byte_ok = 1'b1; byte_data = 8'($urandom);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        exp_m = '0;
        commit(1'b0, base);

        // random mix
        for (int t = 0; t < 14; t++) begin
            prot_on = ($urandom % 3) == 0;
            prot_lo = 13'($urandom);
            txn(16'($urandom), int'($urandom_range(0, 80)), ($urandom % 2) == 1);
        end
        prot_on = 1'b0;
        repeat (4) @(negedge clk);
        summary();
    end

endmodule